// File: doc/BRIEF.md
# Bank-Switched Dual-Port Memory

This block is a synchronous two-port RAM whose word space is cut into four equal banks. Each bank has one static ownership input. That input hands the whole bank to either the left port or the right port. Both ports have a chip enable, a write enable, byte-lane enables, an address and 16-bit write and read data. A port has full read and write access to the banks it owns. Its accesses to any other bank are dropped without effect.

No arbitration takes place. Each bank has exactly one owner at any moment, so the two ports can never both write the same word in one cycle. A system divides the memory by setting the ownership inputs. It can move a bank from one side to the other while traffic continues in the banks that stay where they are.

Read data is registered. When the previous cycle did not perform a granted read, the read output shows a fixed marker word, 16'hDEAD. This covers an idle cycle, a write and an access to a foreign bank.

Top module: `dual_bank_ram`

## Requirements
- R1: The two most significant address bits select the bank (00 is the lowest quarter of the address space, 11 the highest). The remaining bits select the word inside that bank.
- R2: Ownership input bit b at 1 gives bank b to the left port. At 0 it gives bank b to the right port.
- R3: An owner write stores only the enabled bytes. Byte-enable bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. Disabled bytes keep their old value.
- R4: A granted read (enable 1, write enable 0) presents the stored word on that port's read data in the cycle after the address is sampled.
- R5: A write to a bank the writing port does not own leaves every memory word unchanged.
- R6: A read from a bank the reading port does not own returns 16'hDEAD one cycle later.
- R7: Both ports may access the memory in the same cycle without interfering. This holds even when both target the same address, where only the owner acts.
- R8: Every one of the 16 ownership patterns is legal, including all banks on one side.
- R9: After reset, after an idle cycle (enable 0) and after a write cycle, the port's read data shows 16'hDEAD.
- R10: Changing the ownership of one bank does not disturb reads or writes in banks whose ownership stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the read-output state |
| bank_owner | input | 4 | Per-bank ownership, 1 = left, 0 = right |
| l_ce | input | 1 | Left access enable |
| l_we | input | 1 | Left write enable |
| l_be | input | 2 | Left byte enables |
| l_addr | input | 8 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data |
| r_ce | input | 1 | Right access enable |
| r_we | input | 1 | Right write enable |
| r_be | input | 2 | Right byte enables |
| r_addr | input | 8 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |

## Verification
The functions that can fall in the same cycle are an owner's write and a lockout of the other port's write or read on the same bank. The bench provokes this on every step of its sweep. Under all 16 ownership patterns, both ports are driven to the same address on every cycle: the owner writes one value while the other port writes its complement, and then both ports read. The outcome is judged against a bench-side model. The owner must read back its own value and the locked-out port must see the marker. A later phase moves one bank back and forth while the other port keeps streaming through an unchanged bank.

// File: rtl/dual_bank_pkg.sv
`timescale 1ns/1ps
package dual_bank_pkg;
  localparam int NUM_BANKS  = 4;
  localparam int BANK_IDX_W = 2;
  localparam logic [15:0] LOCKOUT_WORD = 16'hDEAD;

  typedef enum logic {
    SIDE_RIGHT = 1'b0,
    SIDE_LEFT  = 1'b1
  } side_e;

  // bank index from the top bits of a word address
  function automatic logic [BANK_IDX_W-1:0] bank_from_addr(input logic [31:0] addr, input int addr_w);
    return BANK_IDX_W'(addr >> (addr_w - BANK_IDX_W));
  endfunction
endpackage

// File: rtl/bank_port_gate.sv
`timescale 1ns/1ps
module bank_port_gate
  import dual_bank_pkg::*;
#(
  parameter int    ADDR_W = 8,
  parameter side_e SIDE   = SIDE_LEFT,
  localparam int   WORD_W = ADDR_W - BANK_IDX_W
) (
  input  logic                  ce,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_BANKS-1:0]  bank_owner,
  output logic [BANK_IDX_W-1:0] bank_idx,
  output logic [WORD_W-1:0]     word_idx,
  output logic                  granted,
  output logic                  rd_granted,
  output logic [NUM_BANKS-1:0]  bank_hit
);
  logic owns_target;

  assign bank_idx    = bank_from_addr(32'(addr), ADDR_W);
  assign word_idx    = addr[WORD_W-1:0];
  assign owns_target = (side_e'(bank_owner[bank_idx]) == SIDE);
  assign granted     = ce && owns_target;
  assign rd_granted  = granted && !we;

  always_comb begin
    bank_hit = '0;
    if (granted) bank_hit[bank_idx] = 1'b1;
  end
endmodule

// File: rtl/bank_store.sv
`timescale 1ns/1ps
module bank_store #(
  parameter int DATA_W = 16,
  parameter int WORD_W = 6,
  localparam int DEPTH = 1 << WORD_W,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [WORD_W-1:0] word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) begin
      for (int g = 0; g < LANES; g++) begin
        if (be[g]) mem[word][g*8 +: 8] <= wdata[g*8 +: 8];
      end
    end
    if (en && !we) q <= mem[word];
  end

  // R10: a bank not being read keeps its output word
  assert_q_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && !we) |=> $stable(q));
endmodule

// File: rtl/dual_bank_ram.sv
`timescale 1ns/1ps
module dual_bank_ram
  import dual_bank_pkg::*;
#(
  parameter int  DATA_W = 16,
  parameter int  ADDR_W = 8,
  localparam int WORD_W = ADDR_W - BANK_IDX_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_owner,
  input  logic                 l_ce,
  input  logic                 l_we,
  input  logic [BE_W-1:0]      l_be,
  input  logic [ADDR_W-1:0]    l_addr,
  input  logic [DATA_W-1:0]    l_wdata,
  output logic [DATA_W-1:0]    l_rdata,
  input  logic                 r_ce,
  input  logic                 r_we,
  input  logic [BE_W-1:0]      r_be,
  input  logic [ADDR_W-1:0]    r_addr,
  input  logic [DATA_W-1:0]    r_wdata,
  output logic [DATA_W-1:0]    r_rdata
);
  localparam logic [DATA_W-1:0] MARK = DATA_W'(LOCKOUT_WORD);

  logic [BANK_IDX_W-1:0] l_bank, r_bank;
  logic [WORD_W-1:0]     l_word, r_word;
  logic                  l_granted, r_granted, l_rd_go, r_rd_go;
  logic [NUM_BANKS-1:0]  l_hit, r_hit;

  bank_port_gate #(.ADDR_W(ADDR_W), .SIDE(SIDE_LEFT)) i_gate_l (
    .ce(l_ce), .we(l_we), .addr(l_addr), .bank_owner(bank_owner),
    .bank_idx(l_bank), .word_idx(l_word), .granted(l_granted),
    .rd_granted(l_rd_go), .bank_hit(l_hit));

  bank_port_gate #(.ADDR_W(ADDR_W), .SIDE(SIDE_RIGHT)) i_gate_r (
    .ce(r_ce), .we(r_we), .addr(r_addr), .bank_owner(bank_owner),
    .bank_idx(r_bank), .word_idx(r_word), .granted(r_granted),
    .rd_granted(r_rd_go), .bank_hit(r_hit));

  logic [NUM_BANKS-1:0] b_en, b_we;
  logic [DATA_W-1:0]    b_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              from_left;
    logic [BE_W-1:0]   sel_be;
    logic [WORD_W-1:0] sel_word;
    logic [DATA_W-1:0] sel_wdata;

    assign from_left = (side_e'(bank_owner[b]) == SIDE_LEFT);
    assign b_en[b]   = from_left ? l_hit[b] : r_hit[b];
    assign b_we[b]   = from_left ? l_we : r_we;
    assign sel_be    = from_left ? l_be : r_be;
    assign sel_word  = from_left ? l_word : r_word;
    assign sel_wdata = from_left ? l_wdata : r_wdata;

    bank_store #(.DATA_W(DATA_W), .WORD_W(WORD_W)) i_store (
      .clk(clk), .rst_n(rst_n), .en(b_en[b]), .we(b_we[b]), .be(sel_be),
      .word(sel_word), .wdata(sel_wdata), .q(b_q[b]));

    // R5: a bank is written only by a port that owns it and addresses it
    assert_owner_only_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (b_en[b] && b_we[b]) |->
        (bank_owner[b] ? (l_ce && l_we && l_addr[ADDR_W-1 -: BANK_IDX_W] == BANK_IDX_W'(b))
                       : (r_ce && r_we && r_addr[ADDR_W-1 -: BANK_IDX_W] == BANK_IDX_W'(b))));
  end

  // registered read selection per port
  logic                  l_rd_ok, r_rd_ok;
  logic [BANK_IDX_W-1:0] l_rd_bank, r_rd_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rd_ok   <= 1'b0;
      r_rd_ok   <= 1'b0;
      l_rd_bank <= '0;
      r_rd_bank <= '0;
    end else begin
      l_rd_ok   <= l_rd_go;
      r_rd_ok   <= r_rd_go;
      l_rd_bank <= l_bank;
      r_rd_bank <= r_bank;
    end
  end

  assign l_rdata = l_rd_ok ? b_q[l_rd_bank] : MARK;
  assign r_rdata = r_rd_ok ? b_q[r_rd_bank] : MARK;

  // R1: an access lands in at most one bank
  assert_single_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(l_hit) && $onehot0(r_hit));

  // R6: a foreign read yields the marker next cycle
  assert_foreign_read_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ce && !l_we && !l_granted) |=> (l_rdata == MARK));
  assert_foreign_read_mark_r_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (r_ce && !r_we && !r_granted) |=> (r_rdata == MARK));

  // R9: idle or write cycles yield the marker next cycle
  assert_idle_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce || l_we) |=> (l_rdata == MARK));
  assert_idle_mark_r_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ce || r_we) |=> (r_rdata == MARK));
endmodule

// File: tb/test_dual_bank_ram.sv
`timescale 1ns/1ps
module test_dual_bank_ram;
  localparam logic [15:0] MARK = 16'hDEAD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bank_owner = 4'hF;
  logic        l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
  logic [1:0]  l_be = 0, r_be = 0;
  logic [7:0]  l_addr = 0, r_addr = 0;
  logic [15:0] l_wdata = 0, r_wdata = 0;
  logic [15:0] l_rdata, r_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] model [256];

  always #2.5 clk = ~clk;

  dual_bank_ram i_dual_bank_ram (
    .clk(clk), .rst_n(rst_n), .bank_owner(bank_owner),
    .l_ce(l_ce), .l_we(l_we), .l_be(l_be), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_ce(r_ce), .r_we(r_we), .r_be(r_be), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata));

  function automatic logic left_owns(input logic [3:0] own, input logic [7:0] a);
    return own[a[7:6]];
  endfunction

  function automatic logic [15:0] pattern(input int a, input int cfg);
    return 16'(a * 16'h0137 + cfg * 16'h0B11 + 16'h0005);
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [1:0] be, input logic [15:0] d);
    return {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_both();
    l_ce = 0; l_we = 0; r_ce = 0; r_we = 0;
  endtask

  // apply a write into the model only when the writer owns the bank
  task automatic model_write(input logic is_left, input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
    if (left_owns(bank_owner, a) == is_left) model[a] = merge(model[a], be, d);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "reset left", l_rdata, MARK);
    check("R9", "reset right", r_rdata, MARK);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R5 R7 R8: sweep all ownership patterns, both ports on one address
    for (int cfg = 0; cfg < 16; cfg++) begin
      bank_owner = 4'(cfg);
      for (int a = 0; a < 256; a++) begin
        logic lo;
        lo = left_owns(bank_owner, 8'(a));
        l_ce = 1; l_we = 1; l_be = 2'b11; l_addr = 8'(a);
        r_ce = 1; r_we = 1; r_be = 2'b11; r_addr = 8'(a);
        l_wdata = lo ? pattern(a, cfg) : ~pattern(a, cfg);
        r_wdata = lo ? ~pattern(a, cfg) : pattern(a, cfg);
        model_write(1'b1, 8'(a), 2'b11, l_wdata);
        model_write(1'b0, 8'(a), 2'b11, r_wdata);
        tick();
        if (a % 64 == 0) begin
          check("R9", "write cycle left", l_rdata, MARK);
          check("R9", "write cycle right", r_rdata, MARK);
        end
      end
      for (int a = 0; a < 256; a++) begin
        logic lo;
        lo = left_owns(bank_owner, 8'(a));
        l_ce = 1; l_we = 0; l_addr = 8'(a);
        r_ce = 1; r_we = 0; r_addr = 8'(a);
        tick();
        check("R1 R2 R4 R5 R7 R8", "left read", l_rdata, lo ? model[a] : MARK);
        check("R1 R2 R4 R5 R6 R7 R8", "right read", r_rdata, lo ? MARK : model[a]);
      end
    end

    // R9: idle cycle
    idle_both();
    tick();
    check("R9", "idle left", l_rdata, MARK);
    check("R9", "idle right", r_rdata, MARK);

    // R3: byte lanes on both sides, banks 0-1 left, 2-3 right
    bank_owner = 4'b0011;
    begin
      logic [1:0]  bes [4] = '{2'b11, 2'b01, 2'b10, 2'b00};
      logic [15:0] ds  [4] = '{16'h1234, 16'hABCD, 16'h5678, 16'hFFFF};
      for (int k = 0; k < 4; k++) begin
        l_ce = 1; l_we = 1; l_be = bes[k]; l_addr = 8'h05; l_wdata = ds[k];
        r_ce = 1; r_we = 1; r_be = bes[k]; r_addr = 8'hC7; r_wdata = ~ds[k];
        model_write(1'b1, 8'h05, bes[k], ds[k]);
        model_write(1'b0, 8'hC7, bes[k], ~ds[k]);
        tick();
        l_we = 0; r_we = 0;
        tick();
        check("R3", "left lane write", l_rdata, model[8'h05]);
        check("R3", "right lane write", r_rdata, model[8'hC7]);
      end
    end
    check("R3", "left lane final", model[8'h05], 16'h56CD);

    // R10: left streams bank 0 while bank 3 flips owner every cycle
    bank_owner = 4'b0001;
    for (int i = 0; i < 32; i++) begin
      bank_owner[3] = 1'(i % 2);
      l_ce = 1; l_we = 0; l_addr = 8'(i);
      r_ce = 1; r_we = 1; r_be = 2'b11; r_addr = 8'(8'hC0 + i); r_wdata = 16'(16'h7000 + i);
      model_write(1'b0, r_addr, 2'b11, r_wdata);
      tick();
      check("R10", "left stream during flip", l_rdata, model[i]);
    end
    bank_owner[3] = 1'b0;
    for (int i = 0; i < 32; i++) begin
      l_ce = 0;
      r_ce = 1; r_we = 0; r_addr = 8'(8'hC0 + i);
      tick();
      check("R10 R5", "bank 3 after flips", r_rdata, model[8'hC0 + i]);
    end

    idle_both();
    tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule